// File: doc/BRIEF.md
# Modified Immediate Constant Expander

This block turns the 12-bit immediate field of an instruction word into the 32-bit constant that an execution unit consumes, together with the shifter carry that goes with it. It understands two encodings, chosen by a select input. In the fixed-width encoding, a byte is rotated right by an even amount. In the compact encoding, the field either repeats a byte across the word in one of four lane patterns, or places a byte whose top bit is forced to one under a five-bit rotation.

The same instruction word also yields the plain immediates used by load/store and add-immediate forms: the 12-bit field zero-extended, and 7-bit and 8-bit fields scaled by four. A separate register-number input is flagged when it names one of the two registers that many compact-form operand slots reject. Everything is combinational, so a decode stage can place the block in front of its pipeline register.

Top module: `imm_expand_unit`

## Requirements
- R1: With `enc_sel` = 0 (fixed form), `imm32` equals `insn[7:0]` zero-extended to 32 bits and rotated right by 2 × `insn[11:8]`.
- R2: In the fixed form, `carry_out` equals `carry_in` when `insn[11:8]` is zero, and equals `imm32[31]` otherwise.
- R3: With `enc_sel` = 1 (compact form), the 12-bit field is built as {`insn[26]`, `insn[14:12]`, `insn[7:0]`} (most significant first); no other instruction bit changes any output.
- R4: In the compact form with field[11:10] = 00, the byte h = field[7:0] is placed according to field[9:8]: 00 gives 0x000000hh, 01 gives 0x00hh00hh, 10 gives 0xhh00hh00, 11 gives 0xhhhhhhhh; `carry_out` equals `carry_in`.
- R5: In the compact form with field[11:10] ≠ 00, `imm32` is the byte {1, field[6:0]} zero-extended and rotated right by field[11:7], and `carry_out` equals `imm32[31]`.
- R6: `unpredictable` is 1 only in the compact form, with field[11:10] = 00, field[9:8] ≠ 00 and field[7:0] = 0; it is 0 in every other case, including the whole fixed form.
- R7: `imm12_zext` is the compact 12-bit field zero-extended, `imm7_x4` is `insn[6:0]` shifted left by 2, and `imm8_x4` is `insn[7:0]` shifted left by 2, all zero-extended to 32 bits and independent of `enc_sel` and `carry_in`.
- R8: `reg_restricted` is 1 exactly when `reg_num` is 13 or 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word holding the immediate fields |
| enc_sel | input | 1 | 0 selects the fixed-width encoding, 1 the compact encoding |
| carry_in | input | 1 | Current carry flag, passed through on unrotated paths |
| reg_num | input | 4 | Register number to screen |
| imm32 | output | 32 | Expanded constant |
| carry_out | output | 1 | Shifter carry produced by the expansion |
| unpredictable | output | 1 | Compact replication pattern applied to a zero byte |
| imm12_zext | output | 32 | Compact 12-bit field, zero-extended |
| imm7_x4 | output | 32 | `insn[6:0]` times four |
| imm8_x4 | output | 32 | `insn[7:0]` times four |
| reg_restricted | output | 1 | `reg_num` is 13 or 15 |

## Verification
The assertions read settled combinational values and take for granted that `insn`, `enc_sel`, `carry_in` and `reg_num` are known (no X or Z) whenever they are evaluated, and that inputs change as a whole vector rather than bit by bit in a way that exposes mixed states. The bench drives each full vector in a single step and samples half a clock period later, so only settled values reach the checks. It sweeps every 12-bit field value with both carry-in values in each encoding, and scatters pseudo-random noise into the bits outside the fields so that the compact form's ignored bits are exercised on every vector.

// File: rtl/imm_expand_pkg.sv
// Shared widths, types and helpers for the immediate expander.
// Assumes the word width is a whole number of bytes.
package imm_expand_pkg;

    parameter int WORD_W  = 32;
    parameter int BYTE_W  = 8;
    parameter int FIELD_W = 12;
    parameter int REG_W   = 4;

    localparam int LANES = WORD_W / BYTE_W;
    localparam int ROT_W = $clog2(WORD_W);

    // Encoding select values.
    typedef enum logic {
        ENC_FIXED   = 1'b0,
        ENC_COMPACT = 1'b1
    } enc_e;

    // Result of one expansion path.
    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
    } imm_res_t;

    // Rotate a word right by amt bit positions.
    function automatic logic [WORD_W-1:0] ror_word(
        input logic [WORD_W-1:0] v,
        input logic [ROT_W-1:0]  amt
    );
        logic [2*WORD_W-1:0] dbl;
        dbl = {v, v} >> amt;
        return dbl[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/imm_field_extract.sv
// Pulls the immediate fields out of the instruction word and forms the
// plain (non-rotated) immediates. Assumes fixed field positions in the
// instruction word; only widths are parameterised.
module imm_field_extract
    import imm_expand_pkg::*;
(
    input  logic [WORD_W-1:0]  insn,
    input  logic [REG_W-1:0]   reg_num,
    output logic [FIELD_W-1:0] imm12,
    output logic [WORD_W-1:0]  imm12_zext,
    output logic [WORD_W-1:0]  imm7_x4,
    output logic [WORD_W-1:0]  imm8_x4,
    output logic               reg_restricted
);

    localparam int PAD12 = WORD_W - FIELD_W;
    localparam int PAD7  = WORD_W - 9;
    localparam int PAD8  = WORD_W - 10;

    // Assemble the compact-form field from its three scattered pieces.
    always_comb begin
        imm12 = {insn[26], insn[14:12], insn[7:0]};
    end

    // Form the zero-extended and scaled immediates.
    always_comb begin
        imm12_zext = {{PAD12{1'b0}}, imm12};
        imm7_x4    = {{PAD7{1'b0}}, insn[6:0], 2'b00};
        imm8_x4    = {{PAD8{1'b0}}, insn[7:0], 2'b00};
    end

    // Flag the two register numbers rejected by many operand slots.
    always_comb begin
        reg_restricted = (reg_num == REG_W'(13)) || (reg_num == REG_W'(15));
    end

    // Restricted numbers are both odd and in the top quarter.
    always_comb begin
        if (reg_restricted) begin
            AST_REG_SCREEN: assert (reg_num[0] && (reg_num[REG_W-1:REG_W-2] == 2'b11))
                else $error("restricted flag on register %0d", reg_num); // R8
        end
    end

endmodule

// File: rtl/imm_fixed_expand.sv
// Fixed-width form: a byte rotated right by twice a 4-bit count.
// Assumes the rotate count field sits directly above the byte.
module imm_fixed_expand
    import imm_expand_pkg::*;
(
    input  logic [WORD_W-1:0] insn,
    input  logic              carry_in,
    output imm_res_t          res
);

    localparam int PADB = WORD_W - BYTE_W;

    logic [3:0]        rot_cnt;
    logic [ROT_W-1:0]  rot_amt;
    logic [WORD_W-1:0] base;

    // Decode the rotate amount (always even) and widen the byte.
    always_comb begin
        rot_cnt = insn[11:8];
        rot_amt = ROT_W'({rot_cnt, 1'b0});
        base    = {{PADB{1'b0}}, insn[BYTE_W-1:0]};
    end

    // Rotate and choose the carry source.
    always_comb begin
        res.value = ror_word(base, rot_amt);
        res.carry = (rot_cnt == 4'd0) ? carry_in : res.value[WORD_W-1];
    end

    // Rotation never creates or destroys set bits.
    always_comb begin
        AST_FIXED_POPCOUNT: assert ($countones(res.value) == $countones(base))
            else $error("fixed rotation changed bit count"); // R1
    end

endmodule

// File: rtl/imm_compact_expand.sv
// Compact form: either replicates a byte across lanes, or rotates a
// byte whose top bit is forced high. Assumes the 12-bit field is
// already assembled by imm_field_extract.
module imm_compact_expand
    import imm_expand_pkg::*;
(
    input  logic [FIELD_W-1:0] imm12,
    input  logic               carry_in,
    output imm_res_t           res,
    output logic               rot_path,
    output logic               unpred
);

    localparam int PADB = WORD_W - BYTE_W;

    logic [1:0]        pat_sel;
    logic [BYTE_W-1:0] hbyte;
    logic [LANES-1:0]  lane_en;
    logic [WORD_W-1:0] repl_word;
    logic [WORD_W-1:0] rot_base;
    logic [ROT_W-1:0]  rot_amt;
    logic [WORD_W-1:0] rot_word;

    // Split the field into path select, pattern select and byte.
    always_comb begin
        rot_path = (imm12[11:10] != 2'b00);
        pat_sel  = imm12[9:8];
        hbyte    = imm12[BYTE_W-1:0];
    end

    // Per-lane enable and byte placement for the replication patterns.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            lane_en[k] = (pat_sel == 2'b11)
                       || ((pat_sel == 2'b01) && (k % 2 == 0))
                       || ((pat_sel == 2'b10) && (k % 2 == 1))
                       || ((pat_sel == 2'b00) && (k == 0));
            repl_word[k*BYTE_W +: BYTE_W] = lane_en[k] ? hbyte : '0;
        end
    end

    // Rotated path: byte with its top bit set, rotated by a 5-bit count.
    always_comb begin
        rot_base = {{PADB{1'b0}}, 1'b1, imm12[6:0]};
        rot_amt  = ROT_W'(imm12[11:7]);
        rot_word = ror_word(rot_base, rot_amt);
    end

    // Select the path and its carry source.
    always_comb begin
        if (rot_path) begin
            res.value = rot_word;
            res.carry = rot_word[WORD_W-1];
        end else begin
            res.value = repl_word;
            res.carry = carry_in;
        end
    end

    // A multi-lane pattern of a zero byte is reserved.
    always_comb begin
        unpred = !rot_path && (pat_sel != 2'b00) && (hbyte == '0);
    end

    // The rotated path always carries the forced bit plus the seven low bits.
    always_comb begin
        if (rot_path) begin
            AST_ROT_POPCOUNT: assert ($countones(res.value) == 1 + $countones(imm12[6:0]))
                else $error("compact rotation lost bits"); // R5
        end
    end

endmodule

// File: rtl/imm_expand_unit.sv
// Top of the immediate expander: runs both encodings in parallel,
// selects one by enc_sel, and exposes the plain immediates and the
// register screen. Purely combinational; assumes known inputs.
module imm_expand_unit
    import imm_expand_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        enc_sel,
    input  logic        carry_in,
    input  logic [3:0]  reg_num,
    output logic [31:0] imm32,
    output logic        carry_out,
    output logic        unpredictable,
    output logic [31:0] imm12_zext,
    output logic [31:0] imm7_x4,
    output logic [31:0] imm8_x4,
    output logic        reg_restricted
);

    logic [FIELD_W-1:0] imm12;
    imm_res_t           fixed_res;
    imm_res_t           compact_res;
    logic               compact_rot;
    logic               compact_unpred;
    enc_e               enc;

    imm_field_extract u_extract (
        .insn           (insn),
        .reg_num        (reg_num),
        .imm12          (imm12),
        .imm12_zext     (imm12_zext),
        .imm7_x4        (imm7_x4),
        .imm8_x4        (imm8_x4),
        .reg_restricted (reg_restricted)
    );

    imm_fixed_expand u_fixed (
        .insn     (insn),
        .carry_in (carry_in),
        .res      (fixed_res)
    );

    imm_compact_expand u_compact (
        .imm12    (imm12),
        .carry_in (carry_in),
        .res      (compact_res),
        .rot_path (compact_rot),
        .unpred   (compact_unpred)
    );

    // Choose the active encoding's result.
    always_comb begin
        enc = enc_e'(enc_sel);
        if (enc == ENC_COMPACT) begin
            imm32         = compact_res.value;
            carry_out     = compact_res.carry;
            unpredictable = compact_unpred;
        end else begin
            imm32         = fixed_res.value;
            carry_out     = fixed_res.carry;
            unpredictable = 1'b0;
        end
    end

    // Cross-path checks on the selected outputs.
    always_comb begin
        if (enc_sel == 1'b0 && insn[11:8] == 4'd0) begin
            AST_FIXED_PASS: assert (carry_out == carry_in && imm32 == {24'd0, insn[7:0]})
                else $error("unrotated fixed form altered value or carry"); // R2
        end
        if (enc_sel == 1'b1 && compact_rot) begin
            AST_ROT_CARRY: assert (carry_out == imm32[31])
                else $error("rotated compact carry is not bit 31"); // R5
        end
        if (enc_sel == 1'b1 && !compact_rot) begin
            AST_REPL_CARRY: assert (carry_out == carry_in)
                else $error("replication pattern altered carry"); // R4
        end
        if (unpredictable) begin
            AST_UNPRED_ZERO: assert (enc_sel == 1'b1 && imm32 == 32'd0)
                else $error("reserved flag on a nonzero or fixed-form result"); // R6
        end
    end

endmodule

// File: tb/sim_imm_expand_unit.sv
// Exhaustive sweep of both encodings with noise outside the fields.
module sim_imm_expand_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic [31:0] insn;
    logic        enc_sel;
    logic        carry_in;
    logic [3:0]  reg_num;
    logic [31:0] imm32;
    logic        carry_out;
    logic        unpredictable;
    logic [31:0] imm12_zext;
    logic [31:0] imm7_x4;
    logic [31:0] imm8_x4;
    logic        reg_restricted;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    imm_expand_unit u0 (
        .insn           (insn),
        .enc_sel        (enc_sel),
        .carry_in       (carry_in),
        .reg_num        (reg_num),
        .imm32          (imm32),
        .carry_out      (carry_out),
        .unpredictable  (unpredictable),
        .imm12_zext     (imm12_zext),
        .imm7_x4        (imm7_x4),
        .imm8_x4        (imm8_x4),
        .reg_restricted (reg_restricted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h (insn=%h enc=%0d cin=%0d)",
                     req, what, got, exp, insn, enc_sel, carry_in);
        end
    endtask

    function automatic logic [31:0] rotr(input logic [31:0] v, input int r);
        if (r == 0) return v;
        return (v >> r) | (v << (32 - r));
    endfunction

    initial begin : main
        logic [31:0] noise;
        logic [31:0] e_val;
        logic        e_cy;
        logic        e_un;
        logic [11:0] f;
        // Reset-like starting vector: all inputs zero.
        insn = '0; enc_sel = 1'b0; carry_in = 1'b0; reg_num = '0;
        #(CLK_PERIOD/2);
        check("R1", "zero imm32", imm32, 32'd0);
        check("R2", "zero carry", {31'd0, carry_out}, 32'd0);
        check("R6", "zero unpred", {31'd0, unpredictable}, 32'd0);
        for (int e = 0; e < 2; e++) begin
            for (int k = 0; k < 4096; k++) begin
                for (int c = 0; c < 2; c++) begin
                    noise = (32'(k) * 32'h9E3779B1) ^ (32'(c) << 29) ^ (32'(e) * 32'h5A5A0000);
                    f = 12'(k);
                    if (e == 0) begin
                        insn = {noise[31:12], f};
                    end else begin
                        insn = noise;
                        insn[26]    = f[11];
                        insn[14:12] = f[10:8];
                        insn[7:0]   = f[7:0];
                    end
                    enc_sel  = e[0];
                    carry_in = c[0];
                    reg_num  = 4'(k);
                    #(CLK_PERIOD/2);
                    if (e == 0) begin
                        e_val = rotr({24'd0, f[7:0]}, 2 * int'(f[11:8]));
                        e_cy  = (f[11:8] == 4'd0) ? c[0] : e_val[31];
                        e_un  = 1'b0;
                        check("R1", "fixed imm32", imm32, e_val);
                        check("R2", "fixed carry", {31'd0, carry_out}, {31'd0, e_cy});
                    end else if (f[11:10] == 2'b00) begin
                        case (f[9:8])
                            2'b00:   e_val = {24'd0, f[7:0]};
                            2'b01:   e_val = 32'(f[7:0]) * 32'h00010001;
                            2'b10:   e_val = 32'(f[7:0]) * 32'h01000100;
                            default: e_val = 32'(f[7:0]) * 32'h01010101;
                        endcase
                        e_cy = c[0];
                        e_un = (f[9:8] != 2'b00) && (f[7:0] == 8'd0);
                        // R3: noise in other bits must not affect the pattern.
                        check("R4", "replicated imm32 (R3 fields)", imm32, e_val);
                        check("R4", "replicated carry", {31'd0, carry_out}, {31'd0, e_cy});
                    end else begin
                        e_val = rotr(32'd128 + 32'(f[6:0]), int'(f[11:7]));
                        e_cy  = e_val[31];
                        e_un  = 1'b0;
                        check("R5", "rotated imm32 (R3 fields)", imm32, e_val);
                        check("R5", "rotated carry", {31'd0, carry_out}, {31'd0, e_cy});
                    end
                    check("R6", "unpredictable", {31'd0, unpredictable}, {31'd0, e_un});
                    check("R7", "imm12_zext", imm12_zext,
                          {20'd0, insn[26], insn[14:12], insn[7:0]});
                    check("R7", "imm7_x4", imm7_x4, 32'(insn[6:0]) * 4);
                    check("R7", "imm8_x4", imm8_x4, 32'(insn[7:0]) * 4);
                    check("R8", "reg_restricted", {31'd0, reg_restricted},
                          {31'd0, (k % 16 == 13) || (k % 16 == 15)});
                    #(CLK_PERIOD/2);
                end
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule